// File: doc/BRIEF.md
# Oversampling UART Receiver

This block is the receive half of a serial port. A 16-bit divisor turns the system clock into a baud-tick enable. Each serial bit lasts either 16 or 13 of those ticks, chosen by one mode input. A two-flop synchronizer cleans the serial line. A falling edge on the idle line starts a frame and restarts the tick prescaler, so the sample points fall a fixed number of ticks after the edge.

The start bit is confirmed at its mid-bit point. Eight data bits follow, least significant first, and then one stop bit. Each finished byte goes into a small show-ahead FIFO together with a framing-error bit. The FIFO raises a service request once its fill reaches a programmable trigger level. A byte that arrives while the FIFO is full is thrown away and sets a sticky overrun flag.

Top module: `osr_uart_rx`

## Requirements
- R1: One bit lasts `divisor` × (ticks per bit) clock cycles, for any divisor from 1 to 65535. A divisor of 0 behaves as 1.
- R2: With `mode13` = 0 a bit lasts 16 ticks, and each bit is sampled on the 8th tick of its bit period, counted from the start edge.
- R3: With `mode13` = 1 a bit lasts 13 ticks, and each bit is sampled on the 6th tick of its bit period.
- R4: A low pulse that has ended before the start-bit sample point produces no byte. The receiver returns to idle.
- R5: A frame is one low start bit, 8 data bits with bit 0 first, and one stop bit. The byte is placed in the FIFO at the stop-bit sample point.
- R6: A stop bit sampled low stores the byte with `rdFrameErr` = 1. A stop bit sampled high stores it with `rdFrameErr` = 0.
- R7: The FIFO returns bytes in arrival order. `rdData` and `rdFrameErr` show the oldest entry. A `popReq` pulse removes that entry, and a pop while the FIFO is empty changes nothing.
- R8: `dataReq` is 1 exactly when `fifoCount` ≥ `trigLevel`. A `trigLevel` of 0 behaves as 1.
- R9: A byte completed while `fifoCount` = FIFO_DEPTH is dropped and sets `overrunFlag`. `fifoCount` stays at FIFO_DEPTH, and the stored bytes are not changed.
- R10: `overrunFlag` stays set until a cycle with `overrunClr` = 1 clears it. If a new overrun happens in that same cycle, the flag stays set.
- R11: After reset, `fifoCount` = 0, `dataReq` = 0 and `overrunFlag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Baud prescaler divisor |
| mode13 | input | 1 | 1 selects 13 ticks per bit, 0 selects 16 |
| rxPin | input | 1 | Serial input line, idle high |
| trigLevel | input | 3 | FIFO fill level that raises `dataReq` |
| popReq | input | 1 | Remove the oldest FIFO entry |
| overrunClr | input | 1 | Write-one-to-clear for `overrunFlag` |
| rdData | output | 8 | Oldest byte in the FIFO |
| rdFrameErr | output | 1 | Framing-error bit of the oldest entry |
| fifoCount | output | 3 | Number of stored bytes |
| dataReq | output | 1 | Service request at or above the trigger level |
| overrunFlag | output | 1 | Sticky overrun indication |

## Verification
The bench sends every one of the 256 byte values in both oversampling modes, so a swapped bit order or a wrong tick count per bit shows up as a corrupted byte.

A 28-clock low pulse at divisor 4 has ended by the 8th tick but is still low at the 6th tick. The 16x mode must reject it, and the 13x mode must accept it as a 0xFF byte. A design that samples at the same point in both modes fails one of these two cases.

Five back-to-back bytes into a four-entry FIFO test overrun handling. A design that overwrote the head, let the count wrap, or lost the sticky flag would return the wrong byte order or the wrong flag. Further cases cover a framing error, a trigger level of 0 and a pop while empty. A design that corrupted its read pointer on an empty pop would return the wrong byte next.

// File: rtl/osr_uart_pkg.sv
package osr_uart_pkg;
  localparam int OS16_TICKS  = 16;
  localparam int OS13_TICKS  = 13;
  localparam int OS16_SAMPLE = 8;
  localparam int OS13_SAMPLE = 6;
  localparam int PHASE_W     = $clog2(OS16_TICKS);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_t;

  typedef struct packed {
    logic baudRestart;
    logic shiftEn;
    logic pushEn;
  } rxStrobe_t;
endpackage

// File: rtl/osr_baud_gen.sv
module osr_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lastCnt;
  logic             wrap;

  // A divisor of zero is handled as one: a tick on every cycle.
  always_comb begin
    lastCnt = (divisor == '0) ? '0 : divisor - DIV_W'(1);
    wrap    = (cnt >= lastCnt);
    tick    = wrap && !restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (restart || wrap) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/osr_rx_ctrl.sv
module osr_rx_ctrl
  import osr_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic      mode13,
  input  logic      rxBit,
  input  logic      fallEdge,
  output rxStrobe_t strb
);
  rxState_t           state;
  logic [PHASE_W-1:0] phase;
  logic [BIT_W-1:0]   bitCnt;
  logic [PHASE_W-1:0] lastPh;
  logic [PHASE_W-1:0] sampPh;
  logic               sampleNow;
  logic               bitEnd;

  // The phase counts ticks 0..N-1 in each bit. The sample is taken on the
  // K-th tick (phase K-1) after the start edge.
  always_comb begin
    lastPh    = mode13 ? PHASE_W'(OS13_TICKS - 1)  : PHASE_W'(OS16_TICKS - 1);
    sampPh    = mode13 ? PHASE_W'(OS13_SAMPLE - 1) : PHASE_W'(OS16_SAMPLE - 1);
    sampleNow = tick && (phase == sampPh);
    bitEnd    = tick && (phase == lastPh);
    strb.baudRestart = (state == RX_IDLE) && fallEdge;
    strb.shiftEn     = (state == RX_DATA) && sampleNow;
    strb.pushEn      = (state == RX_STOP) && sampleNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (state == RX_IDLE) begin
      phase <= '0;
    end else if (tick) begin
      phase <= (phase == lastPh) ? '0 : phase + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        RX_IDLE: begin
          if (fallEdge) state <= RX_START;
        end
        RX_START: begin
          if (sampleNow && rxBit) begin
            state <= RX_IDLE;
          end else if (bitEnd) begin
            state  <= RX_DATA;
            bitCnt <= '0;
          end
        end
        RX_DATA: begin
          if (bitEnd) begin
            if (bitCnt == BIT_W'(DATA_W - 1)) state <= RX_STOP;
            else bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        RX_STOP: begin
          if (sampleNow) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/osr_rx_datapath.sv
module osr_rx_datapath
  import osr_uart_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2,
  localparam int AW    = $clog2(FIFO_DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  rxStrobe_t         strb,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              popReq,
  input  logic              overrunClr,
  output logic              rxBit,
  output logic              fallEdge,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFrameErr,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              dataReq,
  output logic              overrunFlag
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;
  logic [DATA_W-1:0]      shReg;
  logic [DATA_W:0]        mem [FIFO_DEPTH];
  logic [AW-1:0]          wrPtr;
  logic [AW-1:0]          rdPtr;
  logic                   full;
  logic                   doPush;
  logic                   doPop;
  logic [CNT_W-1:0]       effTrig;

  // Synchronizer chain, idle high out of reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '1;
      rxPrev <= 1'b1;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxPin};
      rxPrev <= rxBit;
    end
  end

  always_comb begin
    rxBit    = syncQ[SYNC_STAGES-1];
    fallEdge = rxPrev && !rxBit;
  end

  // The line is sent least significant bit first, so bits shift in from the top.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '0;
    else if (strb.shiftEn) shReg <= {rxBit, shReg[DATA_W-1:1]};
  end

  always_comb begin
    full    = (fifoCount == CNT_W'(FIFO_DEPTH));
    doPush  = strb.pushEn && !full;
    doPop   = popReq && (fifoCount != '0);
    effTrig = (trigLevel == '0) ? CNT_W'(1) : trigLevel;
    dataReq = (fifoCount >= effTrig);
    {rdFrameErr, rdData} = mem[rdPtr];
  end

  // Each entry holds the framing-error bit above the data byte.
  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {!rxBit, shReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fifoCount <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      fifoCount <= fifoCount + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // A new overrun takes priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   overrunFlag <= 1'b0;
    else if (strb.pushEn && full) overrunFlag <= 1'b1;
    else if (overrunClr)         overrunFlag <= 1'b0;
  end
endmodule

// File: rtl/osr_uart_rx.sv
module osr_uart_rx
  import osr_uart_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              mode13,
  input  logic              rxPin,
  input  logic [CNT_W-1:0]  trigLevel,
  input  logic              popReq,
  input  logic              overrunClr,
  output logic [DATA_W-1:0] rdData,
  output logic              rdFrameErr,
  output logic [CNT_W-1:0]  fifoCount,
  output logic              dataReq,
  output logic              overrunFlag
);
  rxStrobe_t strb;
  logic      tick;
  logic      rxBit;
  logic      fallEdge;

  osr_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rstN(rstN), .divisor(divisor),
    .restart(strb.baudRestart), .tick(tick)
  );

  osr_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .mode13(mode13),
    .rxBit(rxBit), .fallEdge(fallEdge), .strb(strb)
  );

  osr_rx_datapath #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .rxPin(rxPin), .strb(strb),
    .trigLevel(trigLevel), .popReq(popReq), .overrunClr(overrunClr),
    .rxBit(rxBit), .fallEdge(fallEdge), .rdData(rdData),
    .rdFrameErr(rdFrameErr), .fifoCount(fifoCount), .dataReq(dataReq),
    .overrunFlag(overrunFlag)
  );
endmodule

// File: rtl/osr_uart_rx_chk.sv
module osr_uart_rx_chk #(
  parameter int FIFO_DEPTH = 4,
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic             dataReq,
  input logic             overrunFlag,
  input logic             overrunClr,
  input logic             popReq
);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(FIFO_DEPTH));

  assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrunFlag) |-> $past(fifoCount) == CNT_W'(FIFO_DEPTH));

  assert_empty_no_request_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoCount == '0) |-> !dataReq);

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !overrunClr) |=> overrunFlag);

  assert_overrun_cleared_R10: assert property (@(posedge clk) disable iff (!rstN)
    (overrunClr && fifoCount != CNT_W'(FIFO_DEPTH)) |=> !overrunFlag);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fifoCount == '0) |=> fifoCount <= CNT_W'(1));
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .dataReq(dataReq),
  .overrunFlag(overrunFlag), .overrunClr(overrunClr), .popReq(popReq)
);

// File: tb/osr_uart_rx_tb.sv
module osr_uart_rx_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] divisor;
  logic        mode13;
  logic        rxPin;
  logic [2:0]  trigLevel;
  logic        popReq;
  logic        overrunClr;
  logic [7:0]  rdData;
  logic        rdFrameErr;
  logic [2:0]  fifoCount;
  logic        dataReq;
  logic        overrunFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  osr_uart_rx #(.DIV_W(16), .DATA_W(8), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .divisor(divisor), .mode13(mode13), .rxPin(rxPin),
    .trigLevel(trigLevel), .popReq(popReq), .overrunClr(overrunClr),
    .rdData(rdData), .rdFrameErr(rdFrameErr), .fifoCount(fifoCount),
    .dataReq(dataReq), .overrunFlag(overrunFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic waitClks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One frame: start, 8 bits LSB first, stop of the given level, 2 idle bits.
  task automatic sendFrame(input logic [7:0] b, input logic stopVal, input int bitClks);
    @(negedge clk);
    rxPin = 1'b0;
    waitClks(bitClks);
    for (int i = 0; i < 8; i++) begin
      rxPin = b[i];
      waitClks(bitClks);
    end
    rxPin = stopVal;
    waitClks(bitClks);
    rxPin = 1'b1;
    waitClks(2 * bitClks);
  endtask

  task automatic popOne();
    @(negedge clk);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    report();
  end

  initial begin
    rstN = 1'b0; divisor = 16'd1; mode13 = 1'b0; rxPin = 1'b1;
    trigLevel = 3'd1; popReq = 1'b0; overrunClr = 1'b0;
    waitClks(5);
    // R11: reset state
    chk("R11 fifoCount", int'(fifoCount), 0);
    chk("R11 dataReq", int'(dataReq), 0);
    chk("R11 overrunFlag", int'(overrunFlag), 0);
    rstN = 1'b1;
    waitClks(5);

    // R2 / R5: all bytes, 16 ticks per bit, divisor 1
    mode13 = 1'b0;
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b1, 16);
      chk("R5 R2 16x byte", int'(rdData), b);
      chk("R2 16x count", int'(fifoCount), 1);
      chk("R6 no frame error", int'(rdFrameErr), 0);
      popOne();
    end

    // R3 / R5: all bytes, 13 ticks per bit, divisor 1
    mode13 = 1'b1;
    for (int b = 0; b < 256; b++) begin
      sendFrame(8'(b), 1'b1, 13);
      chk("R5 R3 13x byte", int'(rdData), b);
      chk("R3 13x count", int'(fifoCount), 1);
      popOne();
    end

    // R1: divisor 3 in 13x mode -> 39 clocks per bit
    divisor = 16'd3;
    sendFrame(8'hA5, 1'b1, 39);
    chk("R1 div3 byte", int'(rdData), 'hA5);
    chk("R1 div3 count", int'(fifoCount), 1);
    popOne();
    // R1: divisor 0 behaves as 1, 16x mode -> 16 clocks per bit
    divisor = 16'd0; mode13 = 1'b0;
    sendFrame(8'h5A, 1'b1, 16);
    chk("R1 div0 byte", int'(rdData), 'h5A);
    chk("R1 div0 count", int'(fifoCount), 1);
    popOne();

    // R4 / R2: 28-clock pulse at divisor 4 ends before the 8th tick (32 clocks)
    divisor = 16'd4; mode13 = 1'b0;
    @(negedge clk); rxPin = 1'b0;
    waitClks(28);
    rxPin = 1'b1;
    waitClks(900);
    chk("R4 R2 short start rejected", int'(fifoCount), 0);
    // R3: same pulse is still low at the 6th tick (24 clocks) -> byte 0xFF
    mode13 = 1'b1;
    @(negedge clk); rxPin = 1'b0;
    waitClks(28);
    rxPin = 1'b1;
    waitClks(700);
    chk("R3 13x sample at 6th tick count", int'(fifoCount), 1);
    chk("R3 13x sample at 6th tick byte", int'(rdData), 'hFF);
    popOne();

    // R6: stop bit low
    divisor = 16'd1; mode13 = 1'b0;
    sendFrame(8'h3C, 1'b0, 16);
    chk("R6 framing byte", int'(rdData), 'h3C);
    chk("R6 framing flag", int'(rdFrameErr), 1);
    popOne();
    chk("R7 empty after pop", int'(fifoCount), 0);

    // R8: trigger level
    trigLevel = 3'd3;
    sendFrame(8'h01, 1'b1, 16);
    sendFrame(8'h02, 1'b1, 16);
    chk("R8 below trigger", int'(dataReq), 0);
    trigLevel = 3'd0;
    @(negedge clk);
    chk("R8 level 0 as 1", int'(dataReq), 1);
    trigLevel = 3'd3;
    sendFrame(8'h03, 1'b1, 16);
    chk("R8 at trigger", int'(dataReq), 1);
    popOne();
    chk("R8 after pop below trigger", int'(dataReq), 0);
    popOne(); popOne();
    chk("R7 drained", int'(fifoCount), 0);

    // R9 / R7: five bytes into four entries
    trigLevel = 3'd4;
    for (int i = 1; i <= 5; i++) sendFrame(8'(i * 'h11), 1'b1, 16);
    chk("R9 count held at depth", int'(fifoCount), DEPTH);
    chk("R9 overrun set", int'(overrunFlag), 1);
    chk("R8 full at trigger 4", int'(dataReq), 1);
    for (int i = 1; i <= 4; i++) begin
      chk("R7 R9 order", int'(rdData), i * 'h11);
      popOne();
    end
    chk("R9 nothing extra stored", int'(fifoCount), 0);
    // R10: sticky, then cleared
    waitClks(20);
    chk("R10 sticky", int'(overrunFlag), 1);
    @(negedge clk); overrunClr = 1'b1;
    @(negedge clk); overrunClr = 1'b0;
    chk("R10 cleared", int'(overrunFlag), 0);

    // R7: pop on empty has no effect
    popOne();
    chk("R7 empty pop count", int'(fifoCount), 0);
    trigLevel = 3'd1;
    sendFrame(8'h77, 1'b1, 16);
    chk("R7 after empty pop byte", int'(rdData), 'h77);
    chk("R7 after empty pop count", int'(fifoCount), 1);
    popOne();

    report();
  end
endmodule